// File: doc/BRIEF.md
# Programmable Serial Frame Transmitter

This block turns one parallel character of up to nine bits into a serial frame on a single output line. Each frame is one low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. The character length, the parity mode and the stop-bit count are set by configuration inputs and can change from one frame to the next. Those inputs are captured when a character is accepted on the valid/ready handshake.

The block runs in one of two modes. In asynchronous mode an external divider supplies a one-cycle `baud_tick`, and each tick starts a new bit period. In synchronous master mode the block also drives a transmit clock. Each tick toggles that clock, so one bit period spans two ticks. The line changes only on the clock edge chosen by `clk_pol`, and the partner samples on the opposite edge. The next character can be accepted during the final stop bit, so frames can follow one another with no idle gap.

Top module: `usart_frame_tx`

## Requirements
- R1: Every frame starts with exactly one start bit at logic 0. It is driven at the first bit launch after the character is accepted.
- R2: `char_sel` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8, and 4 to 7 give 9. Data bits go out least significant bit first. Input bits above the selected length are ignored.
- R3: `par_sel` sets the parity. 0 and 3 mean no parity bit. 1 means even parity and 2 means odd parity. With even parity, the number of ones in the data bits plus the parity bit is even. With odd parity it is odd. The parity bit follows the last data bit.
- R4: Stop bits are logic 1. When `two_stop` is 1 there are two stop bits; otherwise there is one.
- R5: In asynchronous mode (`sync_en` = 0), each `baud_tick` launches one bit, and `xck` stays at the captured `clk_pol` level.
- R6: In synchronous mode (`sync_en` = 1), each `baud_tick` toggles `xck`, and `xck` rests at the `clk_pol` level. With `clk_pol` = 0, `txd` changes only together with a rising `xck` edge. With `clk_pol` = 1, it changes only with a falling edge.
- R7: After reset `txd` = 1, `xck` = 0 and `in_ready` = 1. Between frames `txd` stays at 1, and it changes only when a bit is launched.
- R8: `in_ready` falls in the cycle after a character is accepted. It stays low until the final stop bit is launched and is high during that stop bit. A character accepted then has its start bit launched in the very next bit slot.
- R9: The configuration inputs are captured when a character is accepted. Changing them during the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | The block can accept a character |
| in_data | input | 9 | Character to send, LSB first |
| char_sel | input | 3 | Data length select |
| par_sel | input | 2 | Parity select |
| two_stop | input | 1 | 1 = two stop bits |
| sync_en | input | 1 | 1 = synchronous master mode |
| clk_pol | input | 1 | Rest level of `xck` and choice of the launch edge |
| baud_tick | input | 1 | One-cycle bit-rate strobe from the divider |
| txd | output | 1 | Serial data line |
| xck | output | 1 | Transmit clock output |

## Verification
In asynchronous mode a bit appears on `txd` in the cycle after the clock edge that sampled `baud_tick`, so the monitor registers the tick and reads the line at the following falling clock edge. In synchronous mode the monitor does not count ticks. It reads `txd` when it sees `xck` move to its rest level, which is the sample edge half a bit after launch. It checks every change of `txd` against an `xck` transition to the launch level in that same cycle. `in_ready` is read at each bit event, and back-to-back frames are checked to start exactly one bit event after the previous final stop bit.

// File: rtl/usart_frame_tx.sv
module usart_frame_tx #(
  parameter int MAXD = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [MAXD-1:0] in_data,
  input  logic [2:0]      char_sel,
  input  logic [1:0]      par_sel,
  input  logic            two_stop,
  input  logic            sync_en,
  input  logic            clk_pol,
  input  logic            baud_tick,
  output logic            txd,
  output logic            xck
);
  localparam int FW = MAXD + 4;
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] sh_q, frame;
  logic [CW-1:0] left_q, len_q, nbits, dlen;
  logic          txd_q, xck_q, sync_q, pol_q;
  logic          par_on, pbit, accept, rest, launch, smp;
  logic [MAXD-1:0] dmask;

  assign dlen   = (char_sel > 3'd4) ? CW'(MAXD) : CW'(5) + CW'(char_sel);
  assign par_on = (par_sel == 2'd1) || (par_sel == 2'd2);
  assign pbit   = (^dmask) ^ (par_sel == 2'd2);
  assign nbits  = CW'(2) + dlen + CW'(par_on) + CW'(two_stop);

  always_comb begin
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAXD; i++) begin
      dmask[i] = (CW'(i) < dlen) ? in_data[i] : 1'b0;
      if (CW'(i) < dlen) frame[i+1] = in_data[i];
    end
    if (par_on) frame[dlen + CW'(1)] = pbit;
  end

  assign in_ready = (left_q == '0);
  assign accept   = in_valid && in_ready;
  assign rest     = (xck_q == pol_q);
  assign launch   = baud_tick && (left_q != '0) && (!sync_q || rest);
  assign smp      = baud_tick && !rest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      len_q  <= '0;
      txd_q  <= 1'b1;
      xck_q  <= 1'b0;
      sync_q <= 1'b0;
      pol_q  <= 1'b0;
    end else begin
      if (launch) begin
        txd_q  <= sh_q[0];
        sh_q   <= {1'b1, sh_q[FW-1:1]};
        left_q <= left_q - CW'(1);
        if (sync_q) xck_q <= ~pol_q;
      end
      if (smp) xck_q <= pol_q;
      if (accept) begin
        sh_q   <= frame;
        left_q <= nbits;
        len_q  <= nbits;
        sync_q <= sync_en;
        pol_q  <= clk_pol;
        if (rest) xck_q <= clk_pol;
      end
    end
  end

  assign txd = txd_q;
  assign xck = xck_q;

  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && left_q == len_q) |=> !txd);
  a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && left_q == CW'(1)) |=> txd);
  a_r6_launch_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && txd != $past(txd)) |-> (xck != pol_q && $past(xck) == pol_q));
  a_r7_line_moves_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (txd != $past(txd)) |-> $past(launch));
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
endmodule

// File: tb/tb_usart_frame_tx.sv
module tb_usart_frame_tx;
  logic clk = 0, rst_n = 0, in_valid = 0, two_stop = 0, sync_en = 0, clk_pol = 0, baud_tick = 0;
  logic [8:0] in_data = 0;
  logic [2:0] char_sel = 0;
  logic [1:0] par_sel = 0;
  logic in_ready, txd, xck;
  int tests = 0, fails = 0, cyc = 0, tcnt = 0;

  typedef struct { logic [12:0] bits; int n; bit b2b; } frm_t;
  frm_t q[$];
  bit mode_now = 0, pol_now = 0, b2b_next = 0;

  usart_frame_tx dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .char_sel(char_sel), .par_sel(par_sel), .two_stop(two_stop),
    .sync_en(sync_en), .clk_pol(clk_pol), .baud_tick(baud_tick), .txd(txd), .xck(xck));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tcnt = (tcnt == 7) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == 0);
  end

  logic tick_d = 0;
  always @(posedge clk) tick_d <= baud_tick;

  function automatic frm_t build(input logic [8:0] d, input int cs, input int ps, input bit ts, input bit bb);
    frm_t f;
    int nd = (cs > 4) ? 9 : 5 + cs;
    int ones = 0;
    f.bits = '1; f.n = 0; f.b2b = bb;
    f.bits[f.n++] = 1'b0;
    for (int i = 0; i < nd; i++) begin f.bits[f.n++] = d[i]; ones += d[i]; end
    if (ps == 1) f.bits[f.n++] = (ones % 2 == 1);
    if (ps == 2) f.bits[f.n++] = (ones % 2 == 0);
    f.bits[f.n++] = 1'b1;
    if (ts) f.bits[f.n++] = 1'b1;
    return f;
  endfunction

  task automatic send(input logic [8:0] d, input int cs, input int ps, input bit ts,
                      input bit sm, input bit pl, input bit bb);
    @(negedge clk);
    in_data = d; char_sel = 3'(cs); par_sel = 2'(ps); two_stop = ts;
    sync_en = sm; clk_pol = pl; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    mode_now = sm; pol_now = pl;
    q.push_back(build(d, cs, ps, ts, bb));
  endtask

  bit inframe = 0;
  int k = 0, idle_ev = 0;
  frm_t cur;
  logic txd_p = 1, xck_p = 0;
  always @(negedge clk) begin
    bit ev;
    if (rst_n) begin
      ev = mode_now ? (xck != xck_p && xck == pol_now) : tick_d;
      if (mode_now && txd != txd_p)
        chk(xck != pol_now && xck_p == pol_now, "R6 launch edge", int'(xck), int'(!pol_now));
      if (!mode_now && tick_d) chk(xck == pol_now, "R5 xck steady", int'(xck), int'(pol_now));
      if (ev && !inframe) begin
        idle_ev++;
        if (txd == 1'b0) begin
          chk(q.size() > 0, "R7 unexpected start", 0, 1);
          if (q.size() > 0) begin
            cur = q.pop_front();
            if (cur.b2b) chk(idle_ev == 1, "R8 back-to-back gap", idle_ev, 1);
            inframe = 1; k = 1;
            chk(in_ready == 1'b0, "R8 ready low at start", int'(in_ready), 0);
          end
        end
      end else if (ev && inframe) begin
        chk(txd == cur.bits[k], $sformatf("R2/R3/R4 bit %0d", k), int'(txd), int'(cur.bits[k]));
        if (k < cur.n - 1) chk(in_ready == 1'b0, "R8 ready low mid-frame", int'(in_ready), 0);
        else if (!mode_now) chk(in_ready == 1'b1, "R8 ready in final stop", int'(in_ready), 1);
        k++;
        if (k == cur.n) begin inframe = 0; idle_ev = 0; end
      end
    end
    txd_p = txd; xck_p = xck;
  end

  task automatic drain();
    @(negedge clk) in_valid = 0;
    while (q.size() != 0 || inframe) @(negedge clk);
    repeat (24) @(negedge clk);
    chk(txd == 1'b1, "R7 idle high", int'(txd), 1);
    chk(in_ready == 1'b1, "R8 ready when idle", int'(in_ready), 1);
    if (mode_now) chk(xck == pol_now, "R6 xck rests", int'(xck), int'(pol_now));
  endtask

  task automatic finish();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R7 reset txd", int'(txd), 1);
    chk(xck == 1'b0, "R7 reset xck", int'(xck), 0);
    chk(in_ready == 1'b1, "R7 reset ready", int'(in_ready), 1);
    rst_n = 1;
    // R1 R2 async 8 data bits, no parity
    send(9'h0A5, 3, 0, 0, 0, 0, 0); drain();
    // R2 R3 5 bits even parity, upper bits ignored
    send(9'h1F7, 0, 1, 0, 0, 0, 0); drain();
    // R3 R4 9 bits odd parity two stops
    send(9'h1C3, 4, 2, 1, 0, 0, 0); drain();
    // R9 config changed during the frame
    send(9'h055, 2, 1, 1, 0, 0, 0);
    @(negedge clk); in_valid = 0; char_sel = 3'd4; par_sel = 2'd2; two_stop = 0; in_data = 9'h1FF;
    drain();
    // R8 back-to-back async
    send(9'h02A, 1, 0, 0, 0, 0, 0);
    send(9'h0B6, 3, 2, 0, 0, 0, 1); drain();
    // R2 char_sel above 4, par_sel 3 means none
    send(9'h16D, 7, 3, 0, 0, 0, 0); drain();
    // R6 sync, rising launch
    send(9'h03C, 3, 0, 0, 1, 0, 0); drain();
    // R6 sync, falling launch, 9E2
    send(9'h155, 4, 1, 1, 1, 1, 0); drain();
    // R8 back-to-back sync
    send(9'h011, 0, 2, 0, 1, 1, 0);
    send(9'h0E4, 2, 1, 1, 1, 1, 1); drain();
    // R5 back to async with pol 1
    send(9'h081, 3, 1, 0, 0, 1, 0); drain();
    finish();
  end
endmodule